// File: doc/BRIEF.md
# Deglitched Power-Good Monitor

This block produces the power-good indication of a step-down regulator's supervisor from flags that analog comparators supply already digitised. Three flags describe the feedback level against the reference: feedback above the upper (good) threshold, feedback below the lower (bad) threshold, and reference above its minimum usable level. Three more flags report the hard fault states: shutdown, supply undervoltage lockout and thermal shutdown. The output `pg_good` is active high and stands for the released state of the open-drain pin. The pin driver lives elsewhere.

The two feedback thresholds are separate, so the monitor has hysteresis. While the feedback sits between them, the output keeps its last state. A change in either direction happens only after the qualifying condition has been present on a fixed number of consecutive clock edges (`DEGLITCH_CYCLES`, 48 by default). Any hard fault pulls the output low at once, in the same cycle. It also throws away any count in progress, so after the fault releases the output must qualify again from zero.

Top module: `pgood_monitor`

## Requirements
- R1: After synchronous reset `pg_good` is 0, and it stays 0 until a full rising qualification completes.
- R2: From not-good, `pg_good` becomes 1 right after the `DEGLITCH_CYCLES`-th consecutive rising edge at which `fb_over_rise`=1, `ref_valid`=1 and no fault is present. After one edge fewer it is still 0.
- R3: From good, `pg_good` becomes 0 right after the `DEGLITCH_CYCLES`-th consecutive edge at which `fb_under_fall`=1, and not one edge earlier.
- R4: From good, `ref_valid`=0 held for `DEGLITCH_CYCLES` consecutive edges drives `pg_good` to 0, even with `fb_under_fall`=0.
- R5: With `fb_over_rise`=0, `fb_under_fall`=0 and `ref_valid`=1 (feedback between the thresholds), `pg_good` keeps its state indefinitely in both states.
- R6: A qualifying condition that is absent on a single edge restarts the count. Another full `DEGLITCH_CYCLES` consecutive edges are then needed.
- R7: While any of `shutdown`, `uvlo` or `thermal_fault` is 1, `pg_good` is 0. This holds within the same cycle, before any clock edge.
- R8: A fault present at an edge discards any partial count. After it releases, the output stays 0 until `DEGLITCH_CYCLES` fresh qualifying edges have passed.
- R9: From not-good, `fb_over_rise`=1 with `ref_valid`=0 never makes `pg_good` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fb_over_rise | input | 1 | Feedback is above the upper (good) threshold |
| fb_under_fall | input | 1 | Feedback is below the lower (bad) threshold |
| ref_valid | input | 1 | Reference is above its minimum usable level |
| shutdown | input | 1 | Regulator disabled; forces not-good |
| uvlo | input | 1 | Internal supply undervoltage lockout; forces not-good |
| thermal_fault | input | 1 | Thermal shutdown; forces not-good |
| pg_good | output | 1 | 1 = power good (pin released), 0 = pin pulled low |

## Verification
A sweep holds every one of the 64 combinations of the six flags for longer than the deglitch window, starting once from the good state and once from the not-good state. A cycle model in the bench predicts the output. This separates combinations that must toggle the output from those that must hold it, and confirms that every fault combination wins over the feedback flags. Directed sequences then count edges exactly. A qualification one edge short must not switch the output, and the full length must switch it. A one-edge gap must restart the count. A single-cycle fault pulse in the middle of a count must push the switch back by a full window after the release. The output must also drop at once when a fault arrives, before any clock edge.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic {
        PG_NOT_GOOD = 1'b0,
        PG_GOOD     = 1'b1
    } pg_state_e;

    typedef struct packed {
        logic fb_over_rise;
        logic fb_under_fall;
        logic ref_valid;
    } fb_flags_t;

    typedef struct packed {
        logic shutdown;
        logic uvlo;
        logic thermal;
    } fault_src_t;

    // Any hard fault source forces the output low.
    function automatic logic any_fault(fault_src_t f);
        return f.shutdown | f.uvlo | f.thermal;
    endfunction

    // The condition that would move the output away from its present state.
    function automatic logic toggle_wanted(pg_state_e s, fb_flags_t f);
        if (s == PG_NOT_GOOD)
            return f.fb_over_rise & f.ref_valid;
        else
            return f.fb_under_fall | ~f.ref_valid;
    endfunction

endpackage

// File: rtl/pg_fault_merge.sv
module pg_fault_merge
    import pg_pkg::*;
(
    input  logic       shutdown,
    input  logic       uvlo,
    input  logic       thermal_fault,
    output fault_src_t src,
    output logic       force_low
);
    always_comb begin
        src.shutdown = shutdown;
        src.uvlo     = uvlo;
        src.thermal  = thermal_fault;
        force_low    = any_fault(src);
    end
endmodule

// File: rtl/pg_edge_qualifier.sv
module pg_edge_qualifier
    import pg_pkg::*;
(
    input  pg_state_e state,
    input  fb_flags_t flags,
    input  logic      force_low,
    output logic      toggle_req
);
    always_comb begin
        toggle_req = toggle_wanted(state, flags) & ~force_low;
    end
endmodule

// File: rtl/pg_deglitch_counter.sv
module pg_deglitch_counter #(
    parameter int COUNT = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic req,
    output logic expired
);
    generate
        if (COUNT <= 1) begin : g_direct
            assign expired = req & ~clear;
        end else begin : g_count
            localparam int CW = $clog2(COUNT);
            localparam logic [CW-1:0] LAST = CW'(COUNT - 1);
            logic [CW-1:0] cnt;

            assign expired = req & ~clear & (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || clear || !req) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
    import pg_pkg::*;
#(
    parameter int DEGLITCH_CYCLES = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_over_rise,
    input  logic fb_under_fall,
    input  logic ref_valid,
    input  logic shutdown,
    input  logic uvlo,
    input  logic thermal_fault,
    output logic pg_good
);
    fb_flags_t  flags;
    fault_src_t faults;
    logic       force_low;
    logic       toggle_req;
    logic       toggle_now;
    pg_state_e  state;

    always_comb begin
        flags.fb_over_rise  = fb_over_rise;
        flags.fb_under_fall = fb_under_fall;
        flags.ref_valid     = ref_valid;
    end

    pg_fault_merge u_fault (
        .shutdown      (shutdown),
        .uvlo          (uvlo),
        .thermal_fault (thermal_fault),
        .src           (faults),
        .force_low     (force_low)
    );

    pg_edge_qualifier u_qual (
        .state      (state),
        .flags      (flags),
        .force_low  (force_low),
        .toggle_req (toggle_req)
    );

    pg_deglitch_counter #(.COUNT(DEGLITCH_CYCLES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (force_low),
        .req     (toggle_req),
        .expired (toggle_now)
    );

    always_ff @(posedge clk) begin
        if (rst || force_low) begin
            state <= PG_NOT_GOOD;
        end else if (toggle_now) begin
            state <= (state == PG_GOOD) ? PG_NOT_GOOD : PG_GOOD;
        end
    end

    // Faults act within the cycle, ahead of the registered state.
    assign pg_good = (state == PG_GOOD) && !force_low;

    logic unused_faults;
    assign unused_faults = ^faults;
endmodule

// File: rtl/pgood_monitor_chk.sv
module pgood_monitor_chk #(
    parameter int DEGLITCH_CYCLES = 48
) (
    input logic clk,
    input logic rst,
    input logic fb_over_rise,
    input logic fb_under_fall,
    input logic ref_valid,
    input logic shutdown,
    input logic uvlo,
    input logic thermal_fault,
    input logic pg_good
);
    localparam int RW = $clog2(DEGLITCH_CYCLES + 1);
    localparam logic [RW-1:0] FULL = RW'(DEGLITCH_CYCLES);

    logic          fault;
    logic          rise_q;
    logic          fall_q;
    logic [RW-1:0] run_rise;
    logic [RW-1:0] run_fall;

    assign fault  = shutdown | uvlo | thermal_fault;
    assign rise_q = fb_over_rise & ref_valid & ~fault;
    assign fall_q = (fb_under_fall | ~ref_valid) & ~fault;

    // Saturating counts of consecutive qualifying edges, kept apart from the design.
    always_ff @(posedge clk) begin
        if (rst || !rise_q) run_rise <= '0;
        else if (run_rise != FULL) run_rise <= run_rise + 1'b1;
        if (rst || !fall_q) run_fall <= '0;
        else if (run_fall != FULL) run_fall <= run_fall + 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> !pg_good); // R1
    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> (run_rise >= FULL)); // R2
    AST_FALL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ($fell(pg_good) && !fault) |-> (run_fall >= FULL)); // R3
    AST_HOLD_GOOD: assert property (@(posedge clk) disable iff (rst)
        (pg_good && !fault && !fb_under_fall && ref_valid) |=> (pg_good || fault)); // R5
    AST_NO_RISE_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (!pg_good && !(fb_over_rise && ref_valid)) |=> !pg_good); // R9
    AST_FAULT_LOW: assert property (@(posedge clk) disable iff (rst)
        fault |-> !pg_good); // R7
endmodule

bind pgood_monitor pgood_monitor_chk #(.DEGLITCH_CYCLES(DEGLITCH_CYCLES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .fb_over_rise  (fb_over_rise),
    .fb_under_fall (fb_under_fall),
    .ref_valid     (ref_valid),
    .shutdown      (shutdown),
    .uvlo          (uvlo),
    .thermal_fault (thermal_fault),
    .pg_good       (pg_good)
);

// File: tb/pgood_monitor_tb_top.sv
`timescale 1ns/1ps
module pgood_monitor_tb_top;
    localparam int N = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rise = 1'b0, fall = 1'b0, refv = 1'b0;
    logic sd = 1'b0, uv = 1'b0, th = 1'b0;
    logic pg_good;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R1";

    // Cycle model derived from the requirements.
    logic m_good = 1'b0;
    int   m_cnt  = 0;

    always #5 clk = ~clk;

    pgood_monitor #(.DEGLITCH_CYCLES(N)) dut_i (
        .clk(clk), .rst(rst), .fb_over_rise(rise), .fb_under_fall(fall),
        .ref_valid(refv), .shutdown(sd), .uvlo(uv), .thermal_fault(th),
        .pg_good(pg_good)
    );

    always @(posedge clk) begin
        logic f, want;
        cyc <= cyc + 1;
        f = sd | uv | th;
        want = m_good ? (fall | ~refv) : (rise & refv);
        if (rst || f) begin
            m_good <= 1'b0; m_cnt <= 0;
        end else if (!want) begin
            m_cnt <= 0;
        end else if (m_cnt == N - 1) begin
            m_good <= ~m_good; m_cnt <= 0;
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    task automatic expect_out(input logic exp, input string req);
        checks++;
        if (pg_good !== exp) begin
            fails++;
            $display("FAIL %s: pg_good=%b expected=%b at cycle %0d", req, pg_good, exp, cyc);
        end
    endtask

    // Advance n edges; after each, compare with the model at the falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            expect_out(m_good & ~(sd | uv | th), cur_req);
        end
    endtask

    task automatic set_in(input logic [5:0] v);
        {rise, fall, refv, sd, uv, th} = v;
    endtask

    task automatic go_good();
        set_in(6'b101000); step(N + 2);
    endtask

    task automatic go_low();
        set_in(6'b000100); step(2); set_in(6'b001000); step(2);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out(1'b0, "R1"); // reset state

        // R2: exact rising qualification length.
        cur_req = "R2";
        set_in(6'b101000);
        step(N - 1); expect_out(1'b0, "R2");
        step(1);     expect_out(1'b1, "R2");

        // R5: hold good between thresholds.
        cur_req = "R5";
        set_in(6'b001000); step(150); expect_out(1'b1, "R5");

        // R6: one-edge gap restarts the falling count.
        cur_req = "R6";
        set_in(6'b011000); step(30);
        set_in(6'b001000); step(1);
        set_in(6'b011000); step(N - 1); expect_out(1'b1, "R6");
        step(1); expect_out(1'b0, "R6");

        // R5: hold not-good between thresholds.
        cur_req = "R5";
        set_in(6'b001000); step(150); expect_out(1'b0, "R5");

        // R3: exact falling qualification length.
        go_good();
        cur_req = "R3";
        set_in(6'b011000); step(N - 1); expect_out(1'b1, "R3");
        step(1); expect_out(1'b0, "R3");

        // R4: reference loss drops the output.
        go_good();
        cur_req = "R4";
        set_in(6'b000000); step(N - 1); expect_out(1'b1, "R4");
        step(1); expect_out(1'b0, "R4");

        // R9: upper-threshold flag without a valid reference.
        cur_req = "R9";
        set_in(6'b100000); step(3 * N); expect_out(1'b0, "R9");

        // R7: each fault drops the output before any edge.
        for (int k = 0; k < 3; k++) begin
            go_good();
            cur_req = "R7";
            set_in(6'b101000 | (6'b000100 >> k));
            #1 expect_out(1'b0, "R7");
            step(3);
            set_in(6'b101000); step(N - 1); expect_out(1'b0, "R8");
            step(1); expect_out(1'b1, "R8");
        end

        // R8: fault pulse discards a partial rising count.
        go_low();
        cur_req = "R8";
        set_in(6'b101000); step(40);
        set_in(6'b101010); step(1);
        set_in(6'b101000); step(N - 1); expect_out(1'b0, "R8");
        step(1); expect_out(1'b1, "R8");

        // Sweep: every flag combination from both starting states.
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 64; v++) begin
                if (s == 0) go_low(); else go_good();
                cur_req = "R5 R7 R9 sweep";
                set_in(6'(v));
                step(N + 4);
            end
        end

        finish_run();
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end
endmodule